// File: doc/BRIEF.md
# GPIO Bank with Set/Clear Registers and Pin Function Select

This block is a bank of 32 general-purpose pins controlled through a small memory-mapped register bus. Every register holds one bit per pin. The output-data and direction bits are never written directly. Software changes them through separate write-one-to-set and write-one-to-clear addresses, so one pin can change without a read-modify-write and without disturbing its neighbours. Further registers hold the pull disable, two function-select planes and a per-pin sleep policy. A read-only level register returns the pad inputs after a two-flop synchronizer.

For each pin the block drives a pad output, an output enable, a pull enable and a pull polarity. It also reports the 2-bit function code of each pin. When a pin is in GPIO mode, its pad is driven from the data and direction registers. When a pin selects one of the three alternate functions, its pad output and output enable are taken from that function's peripheral inputs. The pull polarity has no register of its own: it follows the pin's output-data bit. While `sleep_req` is high, each pin whose sleep-policy bit is 0 stops driving and is left with only its pull.

All writes take effect on the clock edge where `bus_wr` is sampled high. Reads are combinational from `bus_addr`. Word addresses: 0x0 level, 0x1 data-set, 0x2 data-clear, 0x3 direction-set, 0x4 direction-clear, 0x5 pull-disable, 0x6 select plane A, 0x7 select plane B, 0x8 sleep policy.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every readable address returns 0. `pad_oe`, `pad_o`, `pad_pu` and `pin_func` are all 0, and `pad_pe` is all ones (all pins are inputs with pulls on).
- R2: A write to 0x1 sets each output-data bit whose write bit is 1 and leaves the others unchanged. Reading 0x1 returns the output-data bits.
- R3: A write to 0x2 clears each output-data bit whose write bit is 1 and leaves the others unchanged. Reading 0x2 returns the output-data bits.
- R4: A write to 0x3 makes each pin whose write bit is 1 an output. A write to 0x4 makes each pin whose write bit is 1 an input. Bits written as 0 are unchanged. Reading 0x3 or 0x4 returns the direction bits, where 1 means output.
- R5: The register at 0x5 is read/write. `pad_pe[i]` is 1 exactly when bit i of this register is 0.
- R6: `pad_pu[i]` equals output-data bit i (1 gives pull-up, 0 gives pull-down). On a GPIO output pin the same bit also sets the driven level.
- R7: Registers 0x6 and 0x7 are read/write. The function code of pin i is {bit i of 0x7, bit i of 0x6}: 0 = GPIO, 1 = A, 2 = B, 3 = C. It appears on `pin_func[2i+1:2i]`.
- R8: With code 0 and no sleep override, `pad_o[i]` is output-data bit i and `pad_oe[i]` is direction bit i.
- R9: With code k in 1..3 and no sleep override, `pad_o[i]` is `alt_o[32(k-1)+i]` and `pad_oe[i]` is `alt_oe[32(k-1)+i]`.
- R10: Reading 0x0 returns `pad_in` through two flops. A change applied between two rising edges is visible after the second of the following rising edges, and not before. Writes to 0x0 are ignored.
- R11: The register at 0x8 is read/write. While `sleep_req` is 1, each pin whose bit is 0 has `pad_oe` = 0 and `pad_o` = 0, and keeps its pull settings. A pin whose bit is 1 keeps its configured drive.
- R12: Addresses 0x9 to 0xF read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sleep_req | input | 1 | Applies the sleep policy to the pads |
| pad_in | input | 32 | Pad input levels, asynchronous |
| alt_o | input | 96 | Pad outputs from functions A, B, C (32 each) |
| alt_oe | input | 96 | Output enables from functions A, B, C |
| pad_o | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pe | output | 32 | Pad pull enable |
| pad_pu | output | 32 | Pull polarity, 1 = up |
| pin_func | output | 64 | 2-bit function code per pin |

## Verification
The bench writes set and clear masks that overlap earlier values. A design that ORed or ANDed the wrong way, or that wrote the mask straight into the register, would corrupt bits the mask did not name. It mixes all four function codes across the bank, so a swapped plane or an off-by-one alternate slice shows up as a wrong pad value on those pins. It checks the level register on both sides of the two-edge synchronizer latency, which catches a missing or extra stage. It also raises `sleep_req` with mixed policy bits, so an inverted policy, or a sleep override that also drops the pull, would disturb the wrong pins.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] RA_LEVEL   = 4'h0;
  localparam logic [ADDR_W-1:0] RA_DSET    = 4'h1;
  localparam logic [ADDR_W-1:0] RA_DCLR    = 4'h2;
  localparam logic [ADDR_W-1:0] RA_DIRSET  = 4'h3;
  localparam logic [ADDR_W-1:0] RA_DIRCLR  = 4'h4;
  localparam logic [ADDR_W-1:0] RA_PULLOFF = 4'h5;
  localparam logic [ADDR_W-1:0] RA_FSELA   = 4'h6;
  localparam logic [ADDR_W-1:0] RA_FSELB   = 4'h7;
  localparam logic [ADDR_W-1:0] RA_KEEP    = 4'h8;

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_A    = 2'd1,
    FN_B    = 2'd2,
    FN_C    = 2'd3
  } pin_fn_e;

  localparam int unsigned NUM_ALT = 3;

  function automatic pin_fn_e fn_decode(input logic plane_a, input logic plane_b);
    return pin_fn_e'({plane_b, plane_a});
  endfunction

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      level,
  output logic [N-1:0]      rdata,
  output logic [N-1:0]      dout_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      poff_q,
  output logic [N-1:0]      fsa_q,
  output logic [N-1:0]      fsb_q,
  output logic [N-1:0]      keep_q
);

  function automatic logic [N-1:0] apply_mask(input logic [N-1:0] cur,
                                               input logic [N-1:0] set_m,
                                               input logic [N-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  logic wr_dset, wr_dclr, wr_dirset, wr_dirclr;
  logic wr_poff, wr_fsa, wr_fsb, wr_keep;

  assign wr_dset   = wr && (addr == RA_DSET);
  assign wr_dclr   = wr && (addr == RA_DCLR);
  assign wr_dirset = wr && (addr == RA_DIRSET);
  assign wr_dirclr = wr && (addr == RA_DIRCLR);
  assign wr_poff   = wr && (addr == RA_PULLOFF);
  assign wr_fsa    = wr && (addr == RA_FSELA);
  assign wr_fsb    = wr && (addr == RA_FSELB);
  assign wr_keep   = wr && (addr == RA_KEEP);

  logic [N-1:0] zero_v;
  assign zero_v = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      poff_q <= '0;
      fsa_q  <= '0;
      fsb_q  <= '0;
      keep_q <= '0;
    end else begin
      if (wr_dset || wr_dclr)
        dout_q <= apply_mask(dout_q, wr_dset ? wdata : zero_v, wr_dclr ? wdata : zero_v);
      if (wr_dirset || wr_dirclr)
        dir_q <= apply_mask(dir_q, wr_dirset ? wdata : zero_v, wr_dirclr ? wdata : zero_v);
      if (wr_poff) poff_q <= wdata;
      if (wr_fsa)  fsa_q  <= wdata;
      if (wr_fsb)  fsb_q  <= wdata;
      if (wr_keep) keep_q <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      RA_LEVEL:             rdata = level;
      RA_DSET, RA_DCLR:     rdata = dout_q;
      RA_DIRSET, RA_DIRCLR: rdata = dir_q;
      RA_PULLOFF:           rdata = poff_q;
      RA_FSELA:             rdata = fsa_q;
      RA_FSELB:             rdata = fsb_q;
      RA_KEEP:              rdata = keep_q;
      default:              rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned N      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[s] <= '0;
      else if (s == 0) stg[s] <= din;
      else             stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/gpio_bank_padmux.sv
module gpio_bank_padmux
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]         dout_q,
  input  logic [N-1:0]         dir_q,
  input  logic [N-1:0]         poff_q,
  input  logic [N-1:0]         fsa_q,
  input  logic [N-1:0]         fsb_q,
  input  logic [N-1:0]         keep_q,
  input  logic                 sleep_req,
  input  logic [NUM_ALT*N-1:0] alt_o,
  input  logic [NUM_ALT*N-1:0] alt_oe,
  output logic [N-1:0]         pad_o,
  output logic [N-1:0]         pad_oe,
  output logic [N-1:0]         pad_pe,
  output logic [N-1:0]         pad_pu,
  output logic [2*N-1:0]       pin_func
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    pin_fn_e fn;
    logic    sel_o, sel_oe, park;

    assign fn   = fn_decode(fsa_q[i], fsb_q[i]);
    assign park = sleep_req && !keep_q[i];

    always_comb begin
      unique case (fn)
        FN_GPIO: begin sel_o = dout_q[i];      sel_oe = dir_q[i];        end
        FN_A:    begin sel_o = alt_o[i];       sel_oe = alt_oe[i];       end
        FN_B:    begin sel_o = alt_o[N+i];     sel_oe = alt_oe[N+i];     end
        default: begin sel_o = alt_o[2*N+i];   sel_oe = alt_oe[2*N+i];   end
      endcase
    end

    assign pad_o[i]         = park ? 1'b0 : sel_o;
    assign pad_oe[i]        = park ? 1'b0 : sel_oe;
    assign pad_pe[i]        = ~poff_q[i];
    assign pad_pu[i]        = dout_q[i];
    assign pin_func[2*i+:2] = fn;
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N          = 32,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [N-1:0]         bus_wdata,
  output logic [N-1:0]         bus_rdata,
  input  logic                 sleep_req,
  input  logic [N-1:0]         pad_in,
  input  logic [NUM_ALT*N-1:0] alt_o,
  input  logic [NUM_ALT*N-1:0] alt_oe,
  output logic [N-1:0]         pad_o,
  output logic [N-1:0]         pad_oe,
  output logic [N-1:0]         pad_pe,
  output logic [N-1:0]         pad_pu,
  output logic [2*N-1:0]       pin_func
);

  logic [N-1:0] level_s;
  logic [N-1:0] dout_q, dir_q, poff_q, fsa_q, fsb_q, keep_q;

  gpio_bank_sync #(.N(N), .STAGES(SYNC_DEPTH)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (level_s)
  );

  gpio_bank_regs #(.N(N)) regs_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .level (level_s),
    .rdata (bus_rdata),
    .dout_q(dout_q),
    .dir_q (dir_q),
    .poff_q(poff_q),
    .fsa_q (fsa_q),
    .fsb_q (fsb_q),
    .keep_q(keep_q)
  );

  gpio_bank_padmux #(.N(N)) mux_i (
    .dout_q   (dout_q),
    .dir_q    (dir_q),
    .poff_q   (poff_q),
    .fsa_q    (fsa_q),
    .fsb_q    (fsb_q),
    .keep_q   (keep_q),
    .sleep_req(sleep_req),
    .alt_o    (alt_o),
    .alt_oe   (alt_oe),
    .pad_o    (pad_o),
    .pad_oe   (pad_oe),
    .pad_pe   (pad_pe),
    .pad_pu   (pad_pu),
    .pin_func (pin_func)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      bus_rdata,
  input logic [N-1:0]      pad_in,
  input logic              sleep_req,
  input logic [N-1:0]      pad_oe,
  input logic [N-1:0]      pad_pe,
  input logic [2*N-1:0]    pin_func,
  input logic [N-1:0]      dout_q,
  input logic [N-1:0]      dir_q,
  input logic [N-1:0]      keep_q
);

  function automatic logic [N-1:0] low_code_bits(input logic [2*N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[2*i];
    return r;
  endfunction

  logic [1:0] live_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  assert_dset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DSET) |=> ((dout_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_dclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DCLR) |=> ((dout_q & $past(bus_wdata)) == '0));

  assert_dirset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_DIRSET) |=> ((dir_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_pulloff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_PULLOFF) |=> (pad_pe == ~$past(bus_wdata)));

  assert_plane_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_FSELA) |=> (low_code_bits(pin_func) == $past(bus_wdata)));

  assert_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2 && bus_addr == RA_LEVEL) |-> (bus_rdata == $past(pad_in, 2)));

  assert_sleep_park_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> ((pad_oe & ~keep_q) == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.N(N)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pad_in   (pad_in),
  .sleep_req(sleep_req),
  .pad_oe   (pad_oe),
  .pad_pe   (pad_pe),
  .pin_func (pin_func),
  .dout_q   (dout_q),
  .dir_q    (dir_q),
  .keep_q   (keep_q)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sleep_req = 1'b0;
  logic [31:0] pad_in = '0;
  logic [95:0] alt_o  = {32'hCCCC_3333, 32'hAAAA_AAAA, 32'h5555_5555};
  logic [95:0] alt_oe = {32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0F0F_0F0F};
  logic [31:0] pad_o, pad_oe, pad_pe, pad_pu;
  logic [63:0] pin_func;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
    .pad_in(pad_in), .alt_o(alt_o), .alt_oe(alt_oe), .pad_o(pad_o),
    .pad_oe(pad_oe), .pad_pe(pad_pe), .pad_pu(pad_pu), .pin_func(pin_func)
  );

  logic [31:0] m_dout, m_dir, m_poff, m_fa, m_fb, m_keep;

  // stimulus: {address, write data}
  localparam logic [35:0] STIM [12] = '{
    {4'h1, 32'hA5A5_0F0F}, {4'h3, 32'hFFFF_0000}, {4'h2, 32'h0000_000F},
    {4'h5, 32'h0000_FF00}, {4'h6, 32'h00F0_0F0F}, {4'h7, 32'h0F00_0FF0},
    {4'h4, 32'h0F0F_0000}, {4'h8, 32'h8000_00FF}, {4'h0, 32'hFFFF_FFFF},
    {4'hC, 32'hFFFF_FFFF}, {4'h1, 32'h0000_0101}, {4'h6, 32'h0000_0003}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_dout = '0; m_dir = '0; m_poff = '0; m_fa = '0; m_fb = '0; m_keep = '0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      4'h1: m_dout = m_dout | d;
      4'h2: m_dout = m_dout & ~d;
      4'h3: m_dir  = m_dir | d;
      4'h4: m_dir  = m_dir & ~d;
      4'h5: m_poff = d;
      4'h6: m_fa   = d;
      4'h7: m_fb   = d;
      4'h8: m_keep = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, input string req, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, $sformatf("read addr %h", a), {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  task automatic check_regs();
    rd(4'h0, "R10", pad_in);
    rd(4'h1, "R2", m_dout);
    rd(4'h2, "R3", m_dout);
    rd(4'h3, "R4", m_dir);
    rd(4'h4, "R4", m_dir);
    rd(4'h5, "R5", m_poff);
    rd(4'h6, "R7", m_fa);
    rd(4'h7, "R7", m_fb);
    rd(4'h8, "R11", m_keep);
    rd(4'hC, "R12", 32'h0);
  endtask

  task automatic check_pads(input string req);
    logic [31:0] eo, eoe;
    logic [63:0] ef;
    bit any_alt = 1'b0;
    for (int i = 0; i < 32; i++) begin
      int code = {m_fb[i], m_fa[i]};
      ef[2*i+:2] = code[1:0];
      if (sleep_req && !m_keep[i]) begin
        eo[i] = 1'b0; eoe[i] = 1'b0;
      end else if (code == 0) begin
        eo[i] = m_dout[i]; eoe[i] = m_dir[i];
      end else begin
        any_alt = 1'b1;
        eo[i]  = alt_o[32*(code-1)+i];
        eoe[i] = alt_oe[32*(code-1)+i];
      end
    end
    #1;
    check(any_alt ? "R9" : "R8", {req, " pad_o"},  {32'h0, pad_o},  {32'h0, eo});
    check(any_alt ? "R9" : "R8", {req, " pad_oe"}, {32'h0, pad_oe}, {32'h0, eoe});
    check("R5", {req, " pad_pe"}, {32'h0, pad_pe}, {32'h0, ~m_poff});
    check("R6", {req, " pad_pu"}, {32'h0, pad_pu}, {32'h0, m_dout});
    check("R7", {req, " pin_func"}, pin_func, ef);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pad_oe at reset", {32'h0, pad_oe}, 64'h0);
    check("R1", "pad_pe at reset", {32'h0, pad_pe}, {32'h0, 32'hFFFF_FFFF});
    check("R1", "pin_func at reset", pin_func, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_regs();
    check_pads("R1");

    // table walk
    for (int k = 0; k < 12; k++) begin
      bus_write(STIM[k][35:32], STIM[k][31:0]);
      check_regs();
      check_pads($sformatf("step %0d", k));
    end

    // R11: sleep override with mixed policy bits
    @(negedge clk);
    sleep_req = 1'b1;
    check_pads("R11 sleep");
    @(negedge clk);
    sleep_req = 1'b0;
    check_pads("R11 wake");

    // R10: synchronizer latency
    @(negedge clk);
    pad_in = 32'h1357_9BDF;
    bus_addr = 4'h0;
    #1 check("R10", "level before edges", {32'h0, bus_rdata}, 64'h0);
    @(negedge clk);
    #1 check("R10", "level after one edge", {32'h0, bus_rdata}, 64'h0);
    @(negedge clk);
    #1 check("R10", "level after two edges", {32'h0, bus_rdata}, {32'h0, 32'h1357_9BDF});

    // R12 / R10: ignored writes leave everything unchanged
    bus_write(4'hF, 32'hFFFF_FFFF);
    bus_write(4'h0, 32'h0);
    check_regs();

    // R6: pull polarity follows data on a GPIO output pin
    bus_write(4'h2, 32'hFFFF_FFFF);
    check_pads("R6 clear all");

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    rd(4'h1, "R1", 32'h0);
    rd(4'h3, "R1", 32'h0);
    rd(4'h8, "R1", 32'h0);
    check_pads("R1 rerun");

    finish_run();
  end

endmodule